// File: doc/BRIEF.md
# Register Ready Scoreboard With Wakeup

This block keeps one ready bit for each physical register and remembers which instruction-queue slots wait on which registers. At dispatch the renamer hands over a slot number, two source tags with a ready hint for each, and an optional destination tag. The hint marks operands that rename already knows to be ready, including unused operands. Any source not marked ready is looked up in the scoreboard. If it is not ready there either, the slot is entered as a waiter on that register.

A completing producer presents its destination tag. Every waiter on that register gets the matching operand marked ready, the register's waiter set is emptied, and its ready bit is set. A squash input drops one slot and removes all of its pending waits. Each slot drives a ready flag per operand and an all-ready flag for the issue selector. Waiters are held as two bit matrices, one per operand position, each with a row per register and a column per slot. Tags at or above the register count are treated as untracked.

Top module: `regwake_sb`

## Requirements
- R1: After reset every register's ready bit is clear and no slot is occupied, so `opa_rdy`, `opb_rdy` and `slot_rdy` are all zero. A source dispatched afterwards with its hint low and no completion of that tag stays not ready.
- R2: A dispatch with `dsp_dst_vld` high and an in-range destination tag clears that register's ready bit. A later dispatch reading that register as a source must wait for its next completion. The caller must not claim a destination whose register still has waiters; that is an assertion error.
- R3: A dispatched source with its hint low is marked ready at once if its register's ready bit is set. Otherwise the slot waits on that register.
- R4: A completion with an in-range tag sets that register's ready bit, marks ready every waiting operand on it, and empties its waiter set. All effects are visible one cycle after the completion.
- R5: A tag greater than or equal to NUM_PREGS is never tracked. As a source it counts as ready at dispatch. As a completion it changes nothing, including for a waiter on the register that shares its low-order bits.
- R6: `opa_rdy[s]` and `opb_rdy[s]` give the operand readiness of an occupied slot s. `slot_rdy[s]` is high only when the slot is occupied and both of its operands are ready. One completion wakes both operands of a slot that wait on the same register.
- R7: A squash empties the slot and removes it from every waiter set. A later dispatch into that slot is therefore never woken by the old registers.
- R8: A completion and a dispatch in the same cycle interact as follows. A dispatched source with the completing tag is seen as ready. If the dispatched destination has the completing tag, the register ends up not ready.
- R9: If a squash and a dispatch name the same slot in the same cycle, the dispatch takes effect.
- R10: Outputs are registered. A dispatch, completion or squash presented in one cycle shows on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_vld | input | 1 | Dispatch this cycle |
| dsp_slot | input | SLOT_W | Queue slot being filled |
| dsp_a_tag | input | TAG_W | First source register tag |
| dsp_a_rdy | input | 1 | Rename says first source is ready or unused |
| dsp_b_tag | input | TAG_W | Second source register tag |
| dsp_b_rdy | input | 1 | Rename says second source is ready or unused |
| dsp_dst_vld | input | 1 | Dispatched instruction writes a register |
| dsp_dst_tag | input | TAG_W | Destination register tag |
| cmp_vld | input | 1 | A producer completes this cycle |
| cmp_tag | input | TAG_W | Destination tag of the completing producer |
| sqh_vld | input | 1 | Squash one slot this cycle |
| sqh_slot | input | SLOT_W | Slot to squash |
| opa_rdy | output | NUM_SLOTS | First operand ready, per slot |
| opb_rdy | output | NUM_SLOTS | Second operand ready, per slot |
| slot_rdy | output | NUM_SLOTS | Slot occupied with all operands ready |

## Verification
The hardest case to reach is a stale waiter. A slot waits on a register, is squashed, and is refilled with a wait on a different register. The old register then completes, and the refilled slot must stay not ready. A directed sequence builds exactly that history. Further directed steps cover the same-cycle races: a dispatch meeting a completion of its source or destination tag, a squash meeting a dispatch on one slot, and an out-of-range completion whose low bits alias a watched register. A long random phase then mixes all four operations. A behavioural per-slot model, which stores waited tags rather than a matrix, is compared against the outputs every cycle.

// File: rtl/regwake_sb.sv
module regwake_sb #(
  parameter int NUM_PREGS = 16,
  parameter int NUM_SLOTS = 8,
  parameter int TAG_W = 5,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int PIDX_W = $clog2(NUM_PREGS)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dsp_vld,
  input  logic [SLOT_W-1:0]    dsp_slot,
  input  logic [TAG_W-1:0]     dsp_a_tag,
  input  logic                 dsp_a_rdy,
  input  logic [TAG_W-1:0]     dsp_b_tag,
  input  logic                 dsp_b_rdy,
  input  logic                 dsp_dst_vld,
  input  logic [TAG_W-1:0]     dsp_dst_tag,
  input  logic                 cmp_vld,
  input  logic [TAG_W-1:0]     cmp_tag,
  input  logic                 sqh_vld,
  input  logic [SLOT_W-1:0]    sqh_slot,
  output logic [NUM_SLOTS-1:0] opa_rdy,
  output logic [NUM_SLOTS-1:0] opb_rdy,
  output logic [NUM_SLOTS-1:0] slot_rdy
);

  logic [NUM_PREGS-1:0] sb;
  logic [NUM_SLOTS-1:0] vld, ra, rb;
  logic [NUM_SLOTS-1:0] wa [NUM_PREGS];
  logic [NUM_SLOTS-1:0] wb [NUM_PREGS];

  wire a_in   = int'(dsp_a_tag) < NUM_PREGS;
  wire b_in   = int'(dsp_b_tag) < NUM_PREGS;
  wire cmp_in = cmp_vld && (int'(cmp_tag) < NUM_PREGS);
  wire dst_in = dsp_vld && dsp_dst_vld && (int'(dsp_dst_tag) < NUM_PREGS);

  wire [PIDX_W-1:0] a_idx   = dsp_a_tag[PIDX_W-1:0];
  wire [PIDX_W-1:0] b_idx   = dsp_b_tag[PIDX_W-1:0];
  wire [PIDX_W-1:0] cmp_idx = cmp_tag[PIDX_W-1:0];
  wire [PIDX_W-1:0] dst_idx = dsp_dst_tag[PIDX_W-1:0];

  wire a_ok = dsp_a_rdy || !a_in || sb[a_idx] || (cmp_in && cmp_tag == dsp_a_tag);
  wire b_ok = dsp_b_rdy || !b_in || sb[b_idx] || (cmp_in && cmp_tag == dsp_b_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb  <= '0;
      vld <= '0;
      ra  <= '0;
      rb  <= '0;
      for (int r = 0; r < NUM_PREGS; r++) begin
        wa[r] <= '0;
        wb[r] <= '0;
      end
    end else begin
      if (cmp_in) begin
        sb[cmp_idx] <= 1'b1;
        wa[cmp_idx] <= '0;
        wb[cmp_idx] <= '0;
      end
      if (dst_in) sb[dst_idx] <= 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cmp_in && wa[cmp_idx][s]) ra[s] <= 1'b1;
        if (cmp_in && wb[cmp_idx][s]) rb[s] <= 1'b1;
        if (sqh_vld && sqh_slot == SLOT_W'(s)) begin
          vld[s] <= 1'b0;
          ra[s]  <= 1'b0;
          rb[s]  <= 1'b0;
          for (int r = 0; r < NUM_PREGS; r++) begin
            wa[r][s] <= 1'b0;
            wb[r][s] <= 1'b0;
          end
        end
        if (dsp_vld && dsp_slot == SLOT_W'(s)) begin
          vld[s] <= 1'b1;
          ra[s]  <= a_ok;
          rb[s]  <= b_ok;
          for (int r = 0; r < NUM_PREGS; r++) begin
            wa[r][s] <= !a_ok && a_idx == PIDX_W'(r);
            wb[r][s] <= !b_ok && b_idx == PIDX_W'(r);
          end
        end
      end
    end
  end

  assign opa_rdy  = vld & ra;
  assign opb_rdy  = vld & rb;
  assign slot_rdy = vld & ra & rb;

  AST_PRODUCER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_in && !(cmp_in && cmp_idx == dst_idx)) |-> (wa[dst_idx] == '0 && wb[dst_idx] == '0)); // R2

  AST_WAKE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_in && !(dst_in && dst_idx == cmp_idx)) |=> sb[$past(cmp_idx)]); // R4

  AST_UNTRACKED_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld && !a_in) |=> opa_rdy[$past(dsp_slot)]); // R5

  AST_SAME_CYCLE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld && !dsp_a_rdy && cmp_in && cmp_tag == dsp_a_tag) |=> opa_rdy[$past(dsp_slot)]); // R8

  AST_SQUASH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (sqh_vld && !(dsp_vld && dsp_slot == sqh_slot)) |=> !opa_rdy[$past(sqh_slot)] && !slot_rdy[$past(sqh_slot)]); // R7

  AST_DISPATCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_vld && sqh_vld && dsp_slot == sqh_slot && dsp_a_rdy && dsp_b_rdy) |=> slot_rdy[$past(dsp_slot)]); // R9

endmodule

// File: tb/test_regwake_sb.sv
module test_regwake_sb;
  localparam int NP = 16, NS = 8, TW = 5, SW = 3;

  logic clk = 0, rst_n = 0;
  logic dsp_vld, dsp_a_rdy, dsp_b_rdy, dsp_dst_vld, cmp_vld, sqh_vld;
  logic [SW-1:0] dsp_slot, sqh_slot;
  logic [TW-1:0] dsp_a_tag, dsp_b_tag, dsp_dst_tag, cmp_tag;
  logic [NS-1:0] opa_rdy, opb_rdy, slot_rdy;

  regwake_sb #(.NUM_PREGS(NP), .NUM_SLOTS(NS), .TAG_W(TW)) i_regwake_sb (
    .clk(clk), .rst_n(rst_n), .dsp_vld(dsp_vld), .dsp_slot(dsp_slot),
    .dsp_a_tag(dsp_a_tag), .dsp_a_rdy(dsp_a_rdy), .dsp_b_tag(dsp_b_tag), .dsp_b_rdy(dsp_b_rdy),
    .dsp_dst_vld(dsp_dst_vld), .dsp_dst_tag(dsp_dst_tag), .cmp_vld(cmp_vld), .cmp_tag(cmp_tag),
    .sqh_vld(sqh_vld), .sqh_slot(sqh_slot), .opa_rdy(opa_rdy), .opb_rdy(opb_rdy), .slot_rdy(slot_rdy));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model: per-slot waited tag (-1 = none)
  bit m_sb [NP];
  bit m_val [NS], m_ra [NS], m_rb [NS];
  int m_ta [NS], m_tb [NS];

  task automatic check(string req, logic [NS-1:0] act, logic [NS-1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) m_sb[i] = 0;
      for (int s = 0; s < NS; s++) begin
        m_val[s] = 0; m_ra[s] = 0; m_rb[s] = 0; m_ta[s] = -1; m_tb[s] = -1;
      end
    end else begin
      int at, bt, ct, dt;
      bit aok, bok;
      at = int'(dsp_a_tag); bt = int'(dsp_b_tag); ct = int'(cmp_tag); dt = int'(dsp_dst_tag);
      aok = dsp_a_rdy || at >= NP || m_sb[at % NP] || (cmp_vld && ct < NP && ct == at);
      bok = dsp_b_rdy || bt >= NP || m_sb[bt % NP] || (cmp_vld && ct < NP && ct == bt);
      if (cmp_vld && ct < NP) begin
        m_sb[ct] = 1;
        for (int s = 0; s < NS; s++) begin
          if (m_ta[s] == ct) begin m_ra[s] = 1; m_ta[s] = -1; end
          if (m_tb[s] == ct) begin m_rb[s] = 1; m_tb[s] = -1; end
        end
      end
      if (dsp_vld && dsp_dst_vld && dt < NP) m_sb[dt] = 0;
      if (sqh_vld) begin
        m_val[sqh_slot] = 0; m_ra[sqh_slot] = 0; m_rb[sqh_slot] = 0;
        m_ta[sqh_slot] = -1; m_tb[sqh_slot] = -1;
      end
      if (dsp_vld) begin
        m_val[dsp_slot] = 1; m_ra[dsp_slot] = aok; m_rb[dsp_slot] = bok;
        m_ta[dsp_slot] = aok ? -1 : at;
        m_tb[dsp_slot] = bok ? -1 : bt;
      end
    end
  end

  // R10: outputs compared one edge after stimulus, every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NS-1:0] ea, eb, er;
      for (int s = 0; s < NS; s++) begin
        ea[s] = m_val[s] && m_ra[s];
        eb[s] = m_val[s] && m_rb[s];
        er[s] = m_val[s] && m_ra[s] && m_rb[s];
      end
      check(cur_req, opa_rdy, ea, "opa_rdy");
      check(cur_req, opb_rdy, eb, "opb_rdy");
      check(cur_req, slot_rdy, er, "slot_rdy");
    end
  end

  task automatic idle();
    dsp_vld = 0; dsp_slot = '0; dsp_a_tag = '0; dsp_a_rdy = 1; dsp_b_tag = '0; dsp_b_rdy = 1;
    dsp_dst_vld = 0; dsp_dst_tag = '0; cmp_vld = 0; cmp_tag = '0; sqh_vld = 0; sqh_slot = '0;
  endtask

  task automatic dsp(int s, int at, bit ar, int bt, bit br, bit dv, int dt);
    dsp_vld = 1; dsp_slot = SW'(s); dsp_a_tag = TW'(at); dsp_a_rdy = ar;
    dsp_b_tag = TW'(bt); dsp_b_rdy = br; dsp_dst_vld = dv; dsp_dst_tag = TW'(dt);
  endtask

  task automatic cmp(int t);
    cmp_vld = 1; cmp_tag = TW'(t);
  endtask

  task automatic sqh(int s);
    sqh_vld = 1; sqh_slot = SW'(s);
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  function automatic bit has_waiter(int t);
    for (int s = 0; s < NS; s++)
      if (m_val[s] && (m_ta[s] == t || m_tb[s] == t)) return 1;
    return 0;
  endfunction

  initial begin
    idle();
    repeat (3) @(negedge clk);
    check("R1", slot_rdy | opa_rdy | opb_rdy, '0, "outputs in reset");
    rst_n = 1;

    cur_req = "R1"; dsp(0, 3, 0, 0, 1, 0, 0); step();
    check("R1", slot_rdy[0], 1'b0, "fresh register not ready");
    cur_req = "R6"; step();
    check("R6", opb_rdy[0], 1'b1, "hinted operand ready alone");
    cur_req = "R4"; cmp(3); step();
    check("R4", slot_rdy[0], 1'b1, "waiter woken");
    cur_req = "R3"; dsp(1, 3, 0, 0, 1, 0, 0); step();
    check("R3", slot_rdy[1], 1'b1, "scoreboard hit at dispatch");
    cur_req = "R2"; dsp(2, 0, 1, 0, 1, 1, 3); step();
    dsp(3, 3, 0, 0, 1, 0, 0); step();
    check("R2", opa_rdy[3], 1'b0, "claimed register waits");
    cmp(3); step();
    check("R2", slot_rdy[3], 1'b1, "claimed register completes");
    cur_req = "R8"; dsp(4, 5, 0, 0, 1, 0, 0); cmp(5); step();
    check("R8", slot_rdy[4], 1'b1, "same-cycle bypass");
    dsp(5, 0, 1, 0, 1, 1, 5); cmp(5); step();
    dsp(6, 5, 0, 0, 1, 0, 0); step();
    check("R8", opa_rdy[6], 1'b0, "same-cycle claim wins");
    cmp(5); step();
    cur_req = "R5"; dsp(7, 4, 0, 20, 0, 0, 0); step();
    check("R5", opb_rdy[7], 1'b1, "untracked source ready");
    check("R5", opa_rdy[7], 1'b0, "reg 4 waiting");
    cmp(20); step();
    check("R5", opa_rdy[7], 1'b0, "untracked completion no alias");
    cmp(4); step();
    check("R5", slot_rdy[7], 1'b1, "real completion wakes");
    cur_req = "R7"; dsp(5, 7, 0, 0, 1, 0, 0); step();
    sqh(5); step();
    check("R7", opa_rdy[5], 1'b0, "squashed slot empty");
    dsp(5, 8, 0, 0, 1, 0, 0); step();
    cmp(7); step();
    check("R7", opa_rdy[5], 1'b0, "stale wait removed");
    cmp(8); step();
    check("R7", slot_rdy[5], 1'b1, "new wait honoured");
    cur_req = "R6"; dsp(2, 9, 0, 9, 0, 0, 0); step();
    check("R6", slot_rdy[2], 1'b0, "both waiting");
    cmp(9); step();
    check("R6", slot_rdy[2], 1'b1, "both woken by one completion");
    cur_req = "R9"; dsp(1, 0, 1, 0, 1, 0, 0); sqh(1); step();
    check("R9", slot_rdy[1], 1'b1, "dispatch beats squash");

    cur_req = "R3/R4/R7/R8 random";
    repeat (4000) begin
      int dt;
      if ($urandom_range(0, 2) != 0) begin
        dt = $urandom_range(0, 19);
        dsp($urandom_range(0, NS-1), $urandom_range(0, 19), $urandom_range(0, 3) == 0,
            $urandom_range(0, 19), $urandom_range(0, 3) == 0,
            (dt >= NP || !has_waiter(dt)) && $urandom_range(0, 1) == 1, dt);
      end
      if ($urandom_range(0, 1) == 1) cmp($urandom_range(0, 19));
      if ($urandom_range(0, 5) == 0) sqh($urandom_range(0, NS-1));
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule